// File: doc/BRIEF.md
# Latched Bus Port with Service Request

This block is an 8-bit port that sits between a processor data bus and a peripheral. It keeps a data latch whose output is qualified by an enable flag, which stands in for a three-state driver. A service-request flop drives an active-low interrupt line. Two device-select inputs of opposite polarity pick the port. A mode pin sets two things: what clocks the latch, and when the output is enabled.

In output mode the processor writes through the port. The output is always enabled, and the latch takes bus data for as long as the port is selected, so it holds the last value written once the port is deselected. In input mode a peripheral loads the latch with its strobe, and the output is enabled only while the processor selects the port. A falling strobe edge raises a service request. The processor's next selection of the port clears that request. Level-sensitive latch behaviour is sampled on the system clock. The latched value appears on `port_q` one clock after the sample that captured it.

Top module: `svcport_top`

## Requirements
- R1: The port counts as selected only when `sel_lo_n` is 0 and `sel_hi` is 1. The other three input combinations leave it unselected.
- R2: With `mode` = 1 (output mode), `port_oe` is 1 in every cycle, whatever the selects are.
- R3: In output mode the latch clock is the selection. On each clock edge where the port is selected, the latch takes `bus_d`. While the port is deselected the latch holds, so after deselection it keeps the last value written. `port_q` shows the latch and lags the capturing edge by one clock.
- R4: With `mode` = 0 (input mode), `port_oe` equals the selection in the same cycle.
- R5: In input mode `stb` is the latch clock. On each edge where `stb` is 1, the latch takes `bus_d`. While `stb` is 0 it holds. If `stb` stays at 1, `port_q` follows `bus_d` one clock later.
- R6: When `clr_n` is 0 on an edge and the latch clock is 0, the latch becomes 0. When the latch clock is 1, it wins over the clear and the latch takes `bus_d`.
- R7: On an edge where `stb` is 0, and `stb` was 1 at the previous edge, the request flop becomes pending, provided the clear is inactive and the port is unselected.
- R8: When `clr_n` is 0 or the port is selected on an edge, the request flop returns to idle. Either of these wins over a strobe falling edge on the same edge.
- R9: `irq_n` is 0 exactly when the request is pending or the port is currently selected, and 1 otherwise.
- R10: After reset, the latch is 0, the request is idle and the stored previous strobe value is 0. A strobe that is already low when reset is released therefore raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_lo_n | input | 1 | Device select, active low |
| sel_hi | input | 1 | Device select, active high |
| mode | input | 1 | 1 = output mode, 0 = input mode |
| stb | input | 1 | Peripheral strobe |
| clr_n | input | 1 | Active-low clear of latch and request |
| bus_d | input | 8 | Data into the latch |
| port_q | output | 8 | Latched data |
| port_oe | output | 1 | Output enable for `port_q` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The select decode is walked through all four select combinations in input mode, where only the true selection should enable the output. In output mode, writes are made with the data changing during the selection and again after it, which shows the difference between capture on deselection and a transparent path. In input mode the strobe is pulsed, held low and held high. This separates latched capture, holding and one-cycle pass-through. It also produces falling edges that are cleared by selection, by the clear input, and by a selection that arrives on the same edge as the fall. Clears are applied both with the latch clock low and with it high, to confirm which input has priority.

// File: rtl/svcport_pkg.sv
package svcport_pkg;
  typedef enum logic {MODE_IN = 1'b0, MODE_OUT = 1'b1} port_mode_e;

  function automatic logic dev_selected(input logic s_lo_n, input logic s_hi);
    return (!s_lo_n) && s_hi;
  endfunction

  function automatic logic falling(input logic prev, input logic now);
    return prev && !now;
  endfunction
endpackage

// File: rtl/svcport_ctrl.sv
module svcport_ctrl
  import svcport_pkg::*;
(
  input  logic sel_lo_n,
  input  logic sel_hi,
  input  logic mode,
  input  logic stb,
  output logic sel,
  output logic lclk,
  output logic oe
);
  port_mode_e pm;
  always_comb begin
    pm  = port_mode_e'(mode);
    sel = dev_selected(sel_lo_n, sel_hi);
    if (pm == MODE_OUT) begin
      lclk = sel;
      oe   = 1'b1;
    end else begin
      lclk = stb;
      oe   = sel;
    end
  end
endmodule

// File: rtl/svcport_latch.sv
module svcport_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lclk,
  input  logic         clr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (lclk)   q <= d;
    else if (!clr_n) q <= '0;
  end
endmodule

// File: rtl/svcport_svcreq.sv
module svcport_svcreq
  import svcport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic sel,
  input  logic clr_n,
  output logic pend,
  output logic fall
);
  logic stb_q;
  assign fall = falling(stb_q, stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      stb_q <= stb;
      if (!clr_n || sel) pend <= 1'b0;
      else if (fall)     pend <= 1'b1;
    end
  end
endmodule

// File: rtl/svcport_top.sv
module svcport_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_lo_n,
  input  logic         sel_hi,
  input  logic         mode,
  input  logic         stb,
  input  logic         clr_n,
  input  logic [W-1:0] bus_d,
  output logic [W-1:0] port_q,
  output logic         port_oe,
  output logic         irq_n
);
  logic sel_w, lclk_w, pend_w, fall_w;

  svcport_ctrl u_ctrl (
    .sel_lo_n(sel_lo_n), .sel_hi(sel_hi), .mode(mode), .stb(stb),
    .sel(sel_w), .lclk(lclk_w), .oe(port_oe)
  );

  svcport_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .lclk(lclk_w), .clr_n(clr_n),
    .d(bus_d), .q(port_q)
  );

  svcport_svcreq u_req (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sel(sel_w), .clr_n(clr_n),
    .pend(pend_w), .fall(fall_w)
  );

  assign irq_n = ~(pend_w | sel_w);
endmodule

// File: rtl/svcport_chk.sv
module svcport_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_lo_n,
  input logic         sel_hi,
  input logic         mode,
  input logic         clr_n,
  input logic [W-1:0] bus_d,
  input logic [W-1:0] port_q,
  input logic         port_oe,
  input logic         irq_n,
  input logic         lclk_w,
  input logic         pend_w,
  input logic         fall_w
);
  a_r2_out_mode_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    mode |-> port_oe);

  a_r4_in_mode_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> (port_oe == (!sel_lo_n && sel_hi)));

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    lclk_w |=> (port_q == $past(bus_d)));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !lclk_w) |=> (port_q == '0));

  a_r7_request: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_w && clr_n && !(!sel_lo_n && sel_hi)) |=> pend_w);

  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n || (!sel_lo_n && sel_hi)) |=> !pend_w);

  a_r9_select_forces_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_lo_n && sel_hi) |-> !irq_n);
endmodule

bind svcport_top svcport_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
  .mode(mode), .clr_n(clr_n), .bus_d(bus_d), .port_q(port_q),
  .port_oe(port_oe), .irq_n(irq_n), .lclk_w(lclk_w),
  .pend_w(pend_w), .fall_w(fall_w)
);

// File: tb/svcport_top_tb.sv
module svcport_top_tb;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_lo_n = 1'b1, sel_hi = 1'b0, mode = 1'b0, stb = 1'b0, clr_n = 1'b1;
  logic [W-1:0] bus_d = '0;
  logic [W-1:0] port_q;
  logic port_oe, irq_n;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string cur = "R10";

  int m_q = 0;
  bit m_pend = 0, m_prev = 0;

  always #5 clk = ~clk;

  svcport_top #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_lo_n(sel_lo_n), .sel_hi(sel_hi),
    .mode(mode), .stb(stb), .clr_n(clr_n), .bus_d(bus_d),
    .port_q(port_q), .port_oe(port_oe), .irq_n(irq_n)
  );

  function automatic bit is_sel();
    return (sel_lo_n == 1'b0) && (sel_hi == 1'b1);
  endfunction

  // Behavioural reference: state updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q = 0; m_pend = 0; m_prev = 0;
    end else begin
      bit takes;
      takes = mode ? is_sel() : (stb == 1'b1);
      if (takes) m_q = int'(bus_d);
      else if (!clr_n) m_q = 0;
      if (!clr_n || is_sel()) m_pend = 0;
      else if (m_prev && !stb) m_pend = 1;
      m_prev = stb;
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(cur, "port_q", int'(port_q), m_q);
    chk(cur, "port_oe", int'(port_oe), int'(mode || is_sel()));
    chk(cur, "irq_n", int'(irq_n), int'(!(m_pend || is_sel())));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state, low strobe at release raises nothing
    cyc();
    chk("R10", "port_q reset", int'(port_q), 0);
    chk("R10", "irq_n reset", int'(irq_n), 1);
    cyc();

    // R1 / R4: select decode in input mode
    cur = "R1";
    for (int k = 0; k < 4; k++) begin
      sel_lo_n = k[0]; sel_hi = k[1];
      #1;
      chk("R1", "port_oe decode", int'(port_oe), int'(k == 2));
      cur = "R4";
      cyc();
    end
    sel_lo_n = 1'b1; sel_hi = 1'b0;
    cyc();

    // R2 / R3: output mode write, capture held after deselect
    cur = "R3"; mode = 1'b1; bus_d = 8'h11;
    cyc();
    chk("R2", "port_oe out mode", int'(port_oe), 1);
    chk("R3", "no capture unselected", int'(port_q), 0);
    sel_lo_n = 1'b0; sel_hi = 1'b1; bus_d = 8'h5A;
    cyc();
    bus_d = 8'hA5;
    cyc();
    sel_lo_n = 1'b1; sel_hi = 1'b0; bus_d = 8'hFF;
    cyc();
    chk("R3", "last written value", int'(port_q), 8'hA5);
    cyc();
    chk("R3", "held after deselect", int'(port_q), 8'hA5);
    stb = 1'b1; cyc(); stb = 1'b0; cyc();
    chk("R3", "strobe ignored in out mode data", int'(port_q), 8'hA5);
    sel_lo_n = 1'b0; sel_hi = 1'b1; cyc(); sel_lo_n = 1'b1; sel_hi = 1'b0; cyc();

    // R5 / R7 / R9: input mode strobe capture and request
    cur = "R5"; mode = 1'b0; bus_d = 8'h3C; stb = 1'b1;
    cyc();
    chk("R5", "strobe capture", int'(port_q), 8'h3C);
    cur = "R7"; stb = 1'b0; bus_d = 8'hC3;
    cyc();
    chk("R5", "hold while strobe low", int'(port_q), 8'h3C);
    chk("R7", "request raised", int'(irq_n), 0);
    cyc();
    chk("R7", "request persists", int'(irq_n), 0);
    cur = "R9"; sel_lo_n = 1'b0; sel_hi = 1'b1;
    cyc();
    chk("R9", "selected forces irq", int'(irq_n), 0);
    sel_lo_n = 1'b1; sel_hi = 1'b0;
    cur = "R8";
    cyc();
    chk("R8", "selection ends request", int'(irq_n), 1);

    // R5: pass-through with strobe held high
    cur = "R5"; stb = 1'b1;
    for (int k = 0; k < 6; k++) begin
      bus_d = 8'(k * 37 + 5);
      cyc();
      chk("R5", "pass-through", int'(port_q), (k * 37 + 5) & 8'hFF);
    end

    // R6: clear with latch clock high loses, with it low wins
    cur = "R6"; clr_n = 1'b0; bus_d = 8'h77;
    cyc();
    chk("R6", "latch clock beats clear", int'(port_q), 8'h77);
    stb = 1'b0;
    cyc();
    chk("R6", "clear empties latch", int'(port_q), 0);
    chk("R8", "clear beats strobe fall", int'(irq_n), 1);
    clr_n = 1'b1;
    cyc();

    // R8: clear drops a pending request
    cur = "R8"; stb = 1'b1; cyc(); stb = 1'b0; cyc();
    chk("R7", "second request", int'(irq_n), 0);
    clr_n = 1'b0; cyc(); clr_n = 1'b1; cyc();
    chk("R8", "clear ends request", int'(irq_n), 1);

    // R8: selection on the same edge as the fall wins
    stb = 1'b1; cyc();
    stb = 1'b0; sel_lo_n = 1'b0; sel_hi = 1'b1; cyc();
    sel_lo_n = 1'b1; sel_hi = 1'b0; cyc();
    chk("R8", "select beats fall", int'(irq_n), 1);

    // R6 in output mode: clear while unselected
    cur = "R6"; mode = 1'b1; sel_lo_n = 1'b0; sel_hi = 1'b1; bus_d = 8'h9E; cyc();
    sel_lo_n = 1'b1; sel_hi = 1'b0; cyc();
    chk("R3", "out-mode write", int'(port_q), 8'h9E);
    clr_n = 1'b0; cyc(); clr_n = 1'b1; cyc();
    chk("R6", "out-mode clear", int'(port_q), 0);

    summary();
  end
endmodule